// File: doc/BRIEF.md
# Gated Oscillator Edge-Count Quantizer

This block models a gated, switchable-rate ring oscillator inside one fast synchronous clock domain and turns its activity into a multi-bit sample stream. A phase accumulator stands in for the oscillator. Two control inputs pick its state: stopped, slow or fast. Each time the accumulator overflows, the oscillator has produced one rising edge. A free-running 16-bit counter counts these edges.

A local divider makes a periodic sampling strobe. A fixed number of cycles after each strobe, once the counter has settled, the counter value is captured. The modulo-2^16 difference between this capture and the one before it is presented as the edge count for that sampling period, and a one-cycle valid pulse goes with it. The slow rate is set above the sampling rate, so every sampling period holds at least one edge and the count needs several bits.

Top module: `gro_edge_quantizer`

## Requirements
- R1: While rst_ni is low, edge_o, strobe_o, valid_o and count_o are all 0. The oscillator phase and the edge counter restart from 0.
- R2: If en_i is low at a rising clock edge, the phase does not change and edge_o is 0 after that edge, whatever fsel_i is.
- R3: If en_i is 1 and fsel_i is 0 at a rising edge, the 16-bit phase advances by FAST_STEP/2. edge_o is 1 after that edge exactly when the addition carries out of bit 15.
- R4: If en_i and fsel_i are both 1 at a rising edge, the phase advances by FAST_STEP, with the same carry rule. Because FAST_STEP is at most 2^15, edge_o is never high on two cycles in a row.
- R5: Stopping keeps the phase. After a stop of any length, the first edge comes when the accumulated phase from before the stop, plus the new steps, carries out.
- R6: strobe_o is a one-cycle pulse, repeated every SAMPLE_DIV cycles.
- R7: valid_o is a one-cycle pulse that comes exactly CAPTURE_DLY+1 cycles after each strobe_o pulse.
- R8: When valid_o is high, count_o equals the number of cycles in which edge_o was high. The window runs from two cycles before the previous valid_o pulse up to two cycles before this one, end inclusive. It is at most SAMPLE_DIV.
- R9: The edge counter wraps at 2^16. The difference is taken modulo 2^16, so a window that spans the wrap still reports its true edge count.
- R10: count_o holds its value between valid_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Oscillator gate: 0 stops it and keeps its phase |
| fsel_i | input | 1 | Rate select while enabled: 0 slow, 1 fast |
| edge_o | output | 1 | One-cycle pulse per emulated oscillator rising edge |
| strobe_o | output | 1 | Sampling strobe, one cycle every SAMPLE_DIV cycles |
| count_o | output | CNT_W | Edge count of the latest sampling period |
| valid_o | output | 1 | Pulses for one cycle when count_o is updated |

## Verification
The bench first runs a directed stop-and-resume sequence from a known phase. If the design reset its phase while gated, the first edge after resuming would come three cycles late. During that stop fsel_i is held high, so decoding the rate select without the enable would show up as stray edges. Random segments of every control combination are then checked cycle by cycle against a phase model and per window against an edge tally. This catches an off-by-one in the capture delay or in the count window, and a slow step that is not half the fast step. A long fast run pushes the counter past 2^16, so a capture that used a plain difference instead of a modular one would report a wrong count on the window that spans the wrap.

// File: rtl/gro_pkg.sv
package gro_pkg;
  typedef enum logic [1:0] {
    OSC_STOP = 2'd0,
    OSC_SLOW = 2'd1,
    OSC_FAST = 2'd2
  } osc_mode_e;

  function automatic osc_mode_e decode_mode(input logic en, input logic fsel);
    if (!en)      return OSC_STOP;
    else if (fsel) return OSC_FAST;
    else           return OSC_SLOW;
  endfunction
endpackage

// File: rtl/gro_phase_acc.sv
module gro_phase_acc
  import gro_pkg::*;
#(
  parameter int ACC_W     = 16,
  parameter int FAST_STEP = 16384
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  osc_mode_e mode_i,
  output logic      edge_o
);
  localparam logic [ACC_W-1:0] FAST_INC = ACC_W'(FAST_STEP);
  localparam logic [ACC_W-1:0] SLOW_INC = ACC_W'(FAST_STEP / 2);

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W:0]   sum;
  logic             edge_q;

  always_comb begin
    unique case (mode_i)
      OSC_FAST: step = FAST_INC;
      OSC_SLOW: step = SLOW_INC;
      default:  step = '0;
    endcase
    sum = {1'b0, phase_q} + {1'b0, step};
  end

  // phase is held (not cleared) while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      edge_q  <= 1'b0;
    end else begin
      phase_q <= sum[ACC_W-1:0];
      edge_q  <= sum[ACC_W];
    end
  end

  assign edge_o = edge_q;
endmodule

// File: rtl/gro_edge_counter.sv
module gro_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (edge_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gro_sample_ctrl.sv
module gro_sample_ctrl #(
  parameter int SAMPLE_DIV  = 20,
  parameter int CAPTURE_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o,
  output logic capture_o
);
  localparam int DIV_W = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      div_q    <= (div_q == DIV_LAST) ? '0 : div_q + DIV_W'(1);
      strobe_q <= (div_q == DIV_LAST);
    end
  end

  assign strobe_o = strobe_q;

  // settle delay between strobe and counter capture
  generate
    if (CAPTURE_DLY == 0) begin : g_no_dly
      assign capture_o = strobe_q;
    end else begin : g_dly
      logic [CAPTURE_DLY-1:0] dly_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= {dly_q, strobe_q};
      end
      assign capture_o = dly_q[CAPTURE_DLY-1];
    end
  endgenerate
endmodule

// File: rtl/gro_count_capture.sv
module gro_count_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] count_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      count_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture_i;
      if (capture_i) begin
        last_q  <= cnt_i;
        count_q <= cnt_i - last_q;  // modular difference absorbs wrap
      end
    end
  end

  assign count_o = count_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/gro_edge_quantizer.sv
module gro_edge_quantizer
  import gro_pkg::*;
#(
  parameter int ACC_W       = 16,
  parameter int FAST_STEP   = 16384,
  parameter int CNT_W       = 16,
  parameter int SAMPLE_DIV  = 20,
  parameter int CAPTURE_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fsel_i,
  output logic             edge_o,
  output logic             strobe_o,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  osc_mode_e        mode;
  logic [CNT_W-1:0] cnt;
  logic             capture;

  assign mode = decode_mode(en_i, fsel_i);

  gro_phase_acc #(.ACC_W(ACC_W), .FAST_STEP(FAST_STEP)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .edge_o (edge_o)
  );

  gro_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edge_o),
    .cnt_o  (cnt)
  );

  gro_sample_ctrl #(.SAMPLE_DIV(SAMPLE_DIV), .CAPTURE_DLY(CAPTURE_DLY)) u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_o  (strobe_o),
    .capture_o (capture)
  );

  gro_count_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .cnt_i     (cnt),
    .count_o   (count_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/gro_quantizer_checker.sv
module gro_quantizer_checker #(
  parameter int CNT_W       = 16,
  parameter int SAMPLE_DIV  = 20,
  parameter int CAPTURE_DLY = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             fsel_i,
  input logic             edge_o,
  input logic             strobe_o,
  input logic [CNT_W-1:0] count_o,
  input logic             valid_o
);
  localparam int CW = $clog2(CAPTURE_DLY + 3) + 1;
  localparam logic [CW-1:0] CTR_MAX = '1;

  logic [CW-1:0] since_strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_strb_q <= CTR_MAX;
    else if (strobe_o)               since_strb_q <= CW'(1);
    else if (since_strb_q != CTR_MAX) since_strb_q <= since_strb_q + CW'(1);
  end

  AST_STOP_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && (fsel_i || !fsel_i)) |=> !edge_o);  // R2
  AST_EDGE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);  // R4
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);  // R6
  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (since_strb_q == CW'(CAPTURE_DLY + 1)));  // R7
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (count_o <= CNT_W'(SAMPLE_DIV)));  // R8
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> (!valid_o -> $stable(count_o)));  // R10
endmodule

bind gro_edge_quantizer gro_quantizer_checker #(
  .CNT_W(CNT_W), .SAMPLE_DIV(SAMPLE_DIV), .CAPTURE_DLY(CAPTURE_DLY)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .fsel_i   (fsel_i),
  .edge_o   (edge_o),
  .strobe_o (strobe_o),
  .count_o  (count_o),
  .valid_o  (valid_o)
);

// File: tb/sim_gro_edge_quantizer.sv
module sim_gro_edge_quantizer;
  localparam int ACC_W       = 16;
  localparam int FAST_STEP   = 32768;
  localparam int CNT_W       = 16;
  localparam int SAMPLE_DIV  = 20;
  localparam int CAPTURE_DLY = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic fsel = 1'b0;
  logic edge_w, strobe_w, valid_w;
  logic [CNT_W-1:0] count_w;

  always #4 clk = ~clk;

  gro_edge_quantizer #(
    .ACC_W(ACC_W), .FAST_STEP(FAST_STEP), .CNT_W(CNT_W),
    .SAMPLE_DIV(SAMPLE_DIV), .CAPTURE_DLY(CAPTURE_DLY)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .fsel_i(fsel),
    .edge_o(edge_w), .strobe_o(strobe_w), .count_o(count_w), .valid_o(valid_w)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // reference oscillator: phase steps from the requirements
  function automatic logic [ACC_W:0] next_phase(input logic [ACC_W-1:0] p, input logic e, input logic f);
    int step;
    step = !e ? 0 : (f ? FAST_STEP : FAST_STEP / 2);
    return {1'b0, p} + (ACC_W+1)'(step);
  endfunction

  logic [ACC_W-1:0] m_phase;
  logic             m_edge;
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_phase <= '0;
      m_edge  <= 1'b0;
    end else begin
      {m_edge, m_phase} <= next_phase(m_phase, en, fsel);
    end
  end

  longint tot = 0, tot_lag = 0, last_snap = 0;
  int cyc = 0, last_strb = -1, pend = -1;
  logic [CNT_W-1:0] last_cnt = '0;
  bit have_cnt = 1'b0;
  bit wrap_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      longint expc;
      cyc++;
      check(edge_w == m_edge, "R3 R4 edge vs phase model", edge_w, m_edge);
      if (strobe_w) begin
        if (last_strb >= 0) check(cyc - last_strb == SAMPLE_DIV, "R6 strobe period", cyc - last_strb, SAMPLE_DIV);
        last_strb = cyc;
        pend = cyc + CAPTURE_DLY + 1;
      end
      if (valid_w || cyc == pend)
        check(valid_w && cyc == pend, "R7 valid timing", valid_w, cyc == pend);
      if (valid_w) begin
        expc = (tot_lag - last_snap) & 64'hFFFF;
        if ((tot_lag & 64'hFFFF) < (last_snap & 64'hFFFF)) begin
          wrap_seen = 1'b1;
          check(count_w == expc, "R9 count across wrap", count_w, expc);
        end else begin
          check(count_w == expc, "R8 window count", count_w, expc);
        end
        last_snap = tot_lag;
        last_cnt  = count_w;
        have_cnt  = 1'b1;
      end else if (have_cnt) begin
        check(count_w == last_cnt, "R10 count hold", count_w, last_cnt);
      end
      tot_lag = tot;
      tot += longint'(edge_w);
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(edge_w == 0 && strobe_w == 0 && valid_w == 0 && count_w == 0, "R1 reset outputs",
          {edge_w, strobe_w, valid_w}, 0);
    rst_ni = 1'b1;
    // R5: slow for 3 steps from phase 0 -> 49152, no edge yet
    en = 1'b1; fsel = 1'b0;
    repeat (3) @(negedge clk);
    check(edge_w == 0, "R3 no edge before wrap", edge_w, 0);
    // R2: stopped with fsel high
    en = 1'b0; fsel = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(edge_w == 0, "R2 stopped no edge", edge_w, 0);
    end
    // R5: resume, held phase gives edge on first slow step
    en = 1'b1; fsel = 1'b0;
    @(negedge clk);
    check(edge_w == 1, "R5 phase held through stop", edge_w, 1);
    // random mode segments
    for (int s = 0; s < 600; s++) begin
      int mode;
      int len;
      mode = $urandom_range(0, 3);
      len  = $urandom_range(1, 40);
      en   = mode[1];
      fsel = mode[0];
      repeat (len) @(negedge clk);
    end
    // long fast run forces the 16-bit counter through wrap
    en = 1'b1; fsel = 1'b1;
    repeat (136000) @(negedge clk);
    en = 1'b0;
    repeat (3 * SAMPLE_DIV) @(negedge clk);
    check(wrap_seen, "R9 wrap window observed", wrap_seen, 1);
    finish_run();
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule